// File: doc/BRIEF.md
# Slot I/O Region Decoder

This block classifies every memory access that falls in the C000–CFFF address range of the four low-memory and slow-memory banks (00, 01, E0 and E1). Each access gets exactly one class. It can be I/O, meaning soft switches or peripheral slot space. It can be internal ROM, in which case the block also supplies the ROM offset. It can be plain RAM, either main or auxiliary. Or it can be a pass-through, meaning the access is left to the general address translator. The classification is combinational from the access inputs and from a small configuration register. That register holds four internal-ROM window selects and an inhibit bit.

The slot space is divided into four windows, each with its own select flag: C1–C2, C3, C4–C7 and C8–CF. The C0 page is always I/O, with one exception. When the inhibit bit is set, banks 00 and 01 lose all I/O and ROM in this range and become ordinary RAM. In that case bank 00 follows the auxiliary read and write selects, and bank 01 uses main RAM. Banks E0 and E1 ignore the inhibit bit. A downstream shadow-write request is dropped for any access classified as I/O.

Top module: `slot_io_decoder`

## Requirements
- R1: An access whose bank is not 00, 01, E0 or E1, or whose address top nibble is not C, asserts only `pass_thru`. All other class outputs are 0 and `rom_addr` is 0.
- R2: Page C0 (address C000–C0FF) is classified as I/O in banks E0 and E1 always, and in banks 00 and 01 while the inhibit bit is 0.
- R3: Select bit 0 covers pages C1–C2, bit 1 covers C3, bit 2 covers C4–C7 and bit 3 covers C8–CF. When the bit for the accessed page is 1, `rom_sel` is 1, `is_io` is 0 and `rom_addr` equals the access address (the same offset as in bank FF).
- R4: When the select bit for an accessed page in C1–CF is 0, the access is classified as I/O and `rom_addr` is 0.
- R5: With the inhibit bit at 1, any C000–CFFF access to bank 00 or 01 asserts `ram_sel`. For bank 00, `ram_aux` equals `aux_wr_sel` on a write and `aux_rd_sel` on a read. For bank 01, `ram_aux` is 0.
- R6: Banks E0 and E1 decode identically whatever the inhibit bit holds.
- R7: `shadow_wr` equals `shadow_req` except when the access is classified as I/O, in which case it is 0.
- R8: A configuration write (`cfg_we`=1) changes decoding from the clock edge that captures it. Before that edge the old configuration applies, and with `cfg_we`=0 the configuration inputs have no effect.
- R9: After reset the inhibit bit and all four select bits are 0.
- R10: Exactly one of `is_io`, `rom_sel`, `ram_sel`, `pass_thru` is 1 for every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Capture configuration inputs on this edge |
| cfg_inhibit | input | 1 | New inhibit bit |
| cfg_rom_sel | input | 4 | New internal-ROM window selects |
| acc_bank | input | 8 | Bank of the access |
| acc_addr | input | 16 | Address within the bank |
| acc_write | input | 1 | 1 for a write access |
| aux_rd_sel | input | 1 | Auxiliary select for reads in bank 00 |
| aux_wr_sel | input | 1 | Auxiliary select for writes in bank 00 |
| shadow_req | input | 1 | Upstream shadow-write indication |
| is_io | output | 1 | Access targets I/O |
| rom_sel | output | 1 | Access targets internal ROM |
| rom_addr | output | 16 | Offset into the top ROM bank when `rom_sel` |
| ram_sel | output | 1 | Access targets plain RAM |
| ram_aux | output | 1 | RAM target is auxiliary memory |
| pass_thru | output | 1 | Access is outside this block's range |
| shadow_wr | output | 1 | Shadow write permitted |

## Verification
Suppose an inhibit bit or window select is held wrongly. The fault shows on the very next access to the affected window, because it flips that access between I/O, ROM and RAM. So a sweep over all pages in all four banks exposes it within one pass per configuration. A fault in configuration capture is visible one clock after the write: either the old decode persists past the capture edge, or the new one appears before it. Every one of the 32 configurations is swept with direct probes of the capture edge, and random accesses fill the gaps, including auxiliary-select and shadow combinations.

// File: rtl/slot_dec_pkg.sv
// Package: shared constants and types of the slot I/O region decoder.
// Assumes windows are expressed as second address nibbles inside the C page range.
package slot_dec_pkg;
    localparam int NUM_WIN = 4;
    localparam int ADDR_W  = 16;
    localparam int BANK_W  = 8;

    typedef logic [3:0] nib_t;

    // First and last page nibble of each internal-ROM window, index = select bit.
    localparam nib_t WIN_FIRST [NUM_WIN] = '{4'h1, 4'h3, 4'h4, 4'h8};
    localparam nib_t WIN_LAST  [NUM_WIN] = '{4'h2, 4'h3, 4'h7, 4'hF};

    localparam nib_t SLOT_NIBBLE = 4'hC;

    typedef enum logic [1:0] {
        BK_NONE,
        BK_LOW_MAIN,
        BK_LOW_ALT,
        BK_SLOW
    } bank_kind_e;
endpackage

// File: rtl/slot_cfg_reg.sv
// Module: holds the inhibit bit and the window selects.
// Assumes a synchronous active-low reset clearing everything.
module slot_cfg_reg #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          inh_in,
    input  logic [NW-1:0] sel_in,
    output logic          inh_q,
    output logic [NW-1:0] sel_q
);
    // Capture a new configuration on a write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_q <= 1'b0;
            sel_q <= '0;
        end else if (we) begin
            inh_q <= inh_in;
            sel_q <= sel_in;
        end
    end
endmodule

// File: rtl/slot_scope.sv
// Module: decides whether an access falls in the decoded banks and page range.
// Assumes the range of interest is the 4 KiB block whose top nibble is SLOT_NIBBLE.
module slot_scope
    import slot_dec_pkg::*;
#(
    parameter int            BW         = 8,
    parameter int            AW         = 16,
    parameter logic [BW-1:0] BANK_MAIN  = 8'h00,
    parameter logic [BW-1:0] BANK_ALT   = 8'h01,
    parameter logic [BW-1:0] BANK_SLOW0 = 8'hE0,
    parameter logic [BW-1:0] BANK_SLOW1 = 8'hE1
) (
    input  logic [BW-1:0] bank,
    input  logic [AW-1:0] addr,
    output bank_kind_e    kind,
    output logic          in_range,
    output nib_t          sub_page
);
    localparam int TOP = AW - 1;

    // Map the bank number onto its decoding class.
    always_comb begin
        if (bank == BANK_MAIN)
            kind = BK_LOW_MAIN;
        else if (bank == BANK_ALT)
            kind = BK_LOW_ALT;
        else if (bank == BANK_SLOW0 || bank == BANK_SLOW1)
            kind = BK_SLOW;
        else
            kind = BK_NONE;
    end

    // Flag accesses inside the slot page range of a decoded bank.
    always_comb begin
        in_range = (kind != BK_NONE) && (addr[TOP -: 4] == SLOT_NIBBLE);
        sub_page = addr[TOP-4 -: 4];
    end
endmodule

// File: rtl/slot_win_match.sv
// Module: finds which ROM window a page nibble belongs to and whether it is enabled.
// Assumes the windows in the package are disjoint.
module slot_win_match
    import slot_dec_pkg::*;
#(
    parameter int NW = NUM_WIN
) (
    input  nib_t          sub_page,
    input  logic [NW-1:0] sel,
    output logic [NW-1:0] win_hit,
    output logic          rom_en
);
    // One range comparator per window.
    for (genvar w = 0; w < NW; w++) begin : g_win
        assign win_hit[w] = (sub_page >= WIN_FIRST[w]) && (sub_page <= WIN_LAST[w]);
    end

    // The page reads ROM when its window's select is set.
    always_comb rom_en = |(win_hit & sel);
endmodule

// File: rtl/slot_io_decoder.sv
// Module: top of the slot I/O region decoder; combines scope, configuration and windows
// into one access class. Assumes inputs are stable around the clock edge.
module slot_io_decoder
    import slot_dec_pkg::*;
#(
    parameter int            NW         = NUM_WIN,
    parameter int            BW         = BANK_W,
    parameter int            AW         = ADDR_W,
    parameter logic [BW-1:0] BANK_MAIN  = 8'h00,
    parameter logic [BW-1:0] BANK_ALT   = 8'h01,
    parameter logic [BW-1:0] BANK_SLOW0 = 8'hE0,
    parameter logic [BW-1:0] BANK_SLOW1 = 8'hE1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_inhibit,
    input  logic [NW-1:0] cfg_rom_sel,
    input  logic [BW-1:0] acc_bank,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_write,
    input  logic          aux_rd_sel,
    input  logic          aux_wr_sel,
    input  logic          shadow_req,
    output logic          is_io,
    output logic          rom_sel,
    output logic [AW-1:0] rom_addr,
    output logic          ram_sel,
    output logic          ram_aux,
    output logic          pass_thru,
    output logic          shadow_wr
);
    logic          inh_q;
    logic [NW-1:0] sel_q;
    bank_kind_e    kind;
    logic          in_range;
    nib_t          sub_page;
    logic [NW-1:0] win_hit;
    logic          rom_en;
    logic          low_bank;

    slot_cfg_reg #(.NW(NW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .inh_in (cfg_inhibit),
        .sel_in (cfg_rom_sel),
        .inh_q  (inh_q),
        .sel_q  (sel_q)
    );

    slot_scope #(
        .BW(BW), .AW(AW),
        .BANK_MAIN(BANK_MAIN), .BANK_ALT(BANK_ALT),
        .BANK_SLOW0(BANK_SLOW0), .BANK_SLOW1(BANK_SLOW1)
    ) u_scope (
        .bank     (acc_bank),
        .addr     (acc_addr),
        .kind     (kind),
        .in_range (in_range),
        .sub_page (sub_page)
    );

    slot_win_match #(.NW(NW)) u_win (
        .sub_page (sub_page),
        .sel      (sel_q),
        .win_hit  (win_hit),
        .rom_en   (rom_en)
    );

    // Low banks are the ones the inhibit bit can turn into RAM.
    always_comb low_bank = (kind == BK_LOW_MAIN) || (kind == BK_LOW_ALT);

    // Select exactly one access class in priority order.
    always_comb begin
        is_io     = 1'b0;
        rom_sel   = 1'b0;
        ram_sel   = 1'b0;
        ram_aux   = 1'b0;
        pass_thru = 1'b0;
        if (!in_range) begin
            pass_thru = 1'b1;
        end else if (low_bank && inh_q) begin
            ram_sel = 1'b1;
            ram_aux = (kind == BK_LOW_MAIN) && (acc_write ? aux_wr_sel : aux_rd_sel);
        end else if (sub_page == 4'h0) begin
            is_io = 1'b1;
        end else if (rom_en) begin
            rom_sel = 1'b1;
        end else begin
            is_io = 1'b1;
        end
    end

    // ROM offset and shadow gating derived from the chosen class.
    always_comb begin
        rom_addr  = rom_sel ? acc_addr : '0;
        shadow_wr = shadow_req && !is_io;
    end
endmodule

// File: rtl/slot_io_decoder_chk.sv
// Module: property checker for the slot I/O region decoder, bound to every instance.
// Assumes the default bank numbering of the top module.
module slot_io_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [7:0]  acc_bank,
    input logic [15:0] acc_addr,
    input logic        acc_write,
    input logic        aux_rd_sel,
    input logic        aux_wr_sel,
    input logic        shadow_req,
    input logic        is_io,
    input logic        rom_sel,
    input logic [15:0] rom_addr,
    input logic        ram_sel,
    input logic        ram_aux,
    input logic        pass_thru,
    input logic        shadow_wr
);
    logic slow_bank;
    logic dec_bank;
    assign slow_bank = (acc_bank == 8'hE0) || (acc_bank == 8'hE1);
    assign dec_bank  = slow_bank || (acc_bank == 8'h00) || (acc_bank == 8'h01);

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_io, rom_sel, ram_sel, pass_thru}) == 1); // R10

    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_bank || acc_addr[15:12] != 4'hC) |-> (pass_thru && rom_addr == 16'h0)); // R1

    AST_SLOW_C0_IO: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_bank && acc_addr[15:8] == 8'hC0) |-> is_io); // R2

    AST_ROM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (rom_addr == acc_addr && acc_addr[15:8] != 8'hC0)); // R3

    AST_ALT_MAIN_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel && acc_bank == 8'h01) |-> !ram_aux); // R5

    AST_SLOW_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        slow_bank |-> !ram_sel); // R6

    AST_IO_NO_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        is_io |-> !shadow_wr); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(acc_bank) && $stable(acc_addr) && $stable(acc_write)
         && $stable(aux_rd_sel) && $stable(aux_wr_sel) && $stable(shadow_req))
        |-> ($stable(is_io) && $stable(rom_sel) && $stable(ram_sel) && $stable(ram_aux))); // R8
endmodule

bind slot_io_decoder slot_io_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .acc_bank   (acc_bank),
    .acc_addr   (acc_addr),
    .acc_write  (acc_write),
    .aux_rd_sel (aux_rd_sel),
    .aux_wr_sel (aux_wr_sel),
    .shadow_req (shadow_req),
    .is_io      (is_io),
    .rom_sel    (rom_sel),
    .rom_addr   (rom_addr),
    .ram_sel    (ram_sel),
    .ram_aux    (ram_aux),
    .pass_thru  (pass_thru),
    .shadow_wr  (shadow_wr)
);

// File: tb/tb_slot_io_decoder.sv
module tb_slot_io_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_inhibit = 1'b0;
    logic [3:0]  cfg_rom_sel = 4'h0;
    logic [7:0]  acc_bank = 8'h20;
    logic [15:0] acc_addr = 16'h0000;
    logic        acc_write = 1'b0;
    logic        aux_rd_sel = 1'b0;
    logic        aux_wr_sel = 1'b0;
    logic        shadow_req = 1'b0;
    logic        is_io, rom_sel, ram_sel, ram_aux, pass_thru, shadow_wr;
    logic [15:0] rom_addr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic       ref_inh = 1'b0;
    logic [3:0] ref_sel = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_io_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_inhibit(cfg_inhibit),
        .cfg_rom_sel(cfg_rom_sel), .acc_bank(acc_bank), .acc_addr(acc_addr),
        .acc_write(acc_write), .aux_rd_sel(aux_rd_sel), .aux_wr_sel(aux_wr_sel),
        .shadow_req(shadow_req), .is_io(is_io), .rom_sel(rom_sel), .rom_addr(rom_addr),
        .ram_sel(ram_sel), .ram_aux(ram_aux), .pass_thru(pass_thru), .shadow_wr(shadow_wr)
    );

    function automatic int win_of(input logic [3:0] p);
        if (p <= 4'h2) return 0;
        if (p == 4'h3) return 1;
        if (p <= 4'h7) return 2;
        return 3;
    endfunction

    // Expected {is_io, rom_sel, ram_sel, ram_aux, pass_thru, shadow_wr, rom_addr}.
    function automatic logic [21:0] expect_of(input logic inh, input logic [3:0] sel,
            input logic [7:0] b, input logic [15:0] a, input logic wr,
            input logic ard, input logic awr, input logic sh);
        logic io, rom, ram, aux, pas;
        logic low, slow;
        io = 0; rom = 0; ram = 0; aux = 0; pas = 0;
        low  = (b == 8'h00) || (b == 8'h01);
        slow = (b == 8'hE0) || (b == 8'hE1);
        if (!(low || slow) || a[15:12] != 4'hC) pas = 1;
        else if (low && inh) begin
            ram = 1;
            aux = (b == 8'h00) ? (wr ? awr : ard) : 1'b0;
        end else if (a[11:8] == 4'h0) io = 1;
        else if (sel[win_of(a[11:8])]) rom = 1;
        else io = 1;
        return {io, rom, ram, aux, pas, sh & ~io, rom ? a : 16'h0};
    endfunction

    function automatic string tag_of(input logic inh, input logic [3:0] sel,
            input logic [7:0] b, input logic [15:0] a, input logic sh);
        logic low, slow;
        low  = (b == 8'h00) || (b == 8'h01);
        slow = (b == 8'hE0) || (b == 8'hE1);
        if (!(low || slow) || a[15:12] != 4'hC) return "R1";
        if (low && inh) return "R5";
        if (sh) return "R7";
        if (slow && inh) return "R6";
        if (a[11:8] == 4'h0) return "R2";
        if (sel[win_of(a[11:8])]) return "R3";
        return "R4";
    endfunction

    task automatic compare(input logic [21:0] exp_v, input string tag);
        logic [21:0] act;
        act = {is_io, rom_sel, ram_sel, ram_aux, pass_thru, shadow_wr, rom_addr};
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s bank=%h addr=%h actual=%h expected=%h",
                     tag, acc_bank, acc_addr, act, exp_v);
        end
        checks++;
        if ($countones({is_io, rom_sel, ram_sel, pass_thru}) != 1) begin
            fails++;
            $display("FAIL R10 classes actual=%b expected one-hot",
                     {is_io, rom_sel, ram_sel, pass_thru});
        end
    endtask

    // Drive one access away from the edge and check it against the bench configuration.
    task automatic access(input logic [7:0] b, input logic [15:0] a, input logic wr,
                          input logic ard, input logic awr, input logic sh);
        @(negedge clk);
        acc_bank = b; acc_addr = a; acc_write = wr;
        aux_rd_sel = ard; aux_wr_sel = awr; shadow_req = sh;
        #1;
        compare(expect_of(ref_inh, ref_sel, b, a, wr, ard, awr, sh),
                tag_of(ref_inh, ref_sel, b, a, sh));
    endtask

    task automatic write_cfg(input logic inh, input logic [3:0] sel);
        @(negedge clk);
        cfg_we = 1'b1; cfg_inhibit = inh; cfg_rom_sel = sel;
        @(posedge clk);
        ref_inh = inh; ref_sel = sel;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_inhibit = $urandom_range(0, 1);
        cfg_rom_sel = 4'($urandom_range(0, 15));
    endtask

    initial begin
        automatic logic [7:0] banks [5] = '{8'h00, 8'h01, 8'hE0, 8'hE1, 8'h02};
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset leaves inhibit clear and all windows as I/O.
        access(8'hE0, 16'hC100, 1'b0, 1'b0, 1'b0, 1'b0);
        access(8'h00, 16'hC800, 1'b0, 1'b1, 1'b1, 1'b0);
        checks++;
        if (!(is_io && !ram_sel)) begin
            fails++;
            $display("FAIL R9 reset io=%b ram=%b expected io=1 ram=0", is_io, ram_sel);
        end

        // R8: new configuration is not visible before the capturing edge.
        @(negedge clk);
        acc_bank = 8'hE1; acc_addr = 16'hC3A0; acc_write = 1'b0; shadow_req = 1'b0;
        cfg_we = 1'b1; cfg_inhibit = 1'b1; cfg_rom_sel = 4'hF;
        #1;
        checks++;
        if (!is_io) begin
            fails++;
            $display("FAIL R8 pre-edge io actual=%b expected=1", is_io);
        end
        @(posedge clk);
        ref_inh = 1'b1; ref_sel = 4'hF;
        #1;
        checks++;
        if (!(rom_sel && rom_addr == 16'hC3A0)) begin
            fails++;
            $display("FAIL R8 post-edge rom actual=%b/%h expected=1/c3a0", rom_sel, rom_addr);
        end
        @(negedge clk);
        cfg_we = 1'b0; cfg_inhibit = 1'b0; cfg_rom_sel = 4'h0;
        // R8: with cfg_we low the configuration inputs are ignored.
        repeat (2) @(posedge clk);
        access(8'h00, 16'hC000, 1'b1, 1'b0, 1'b1, 1'b0);
        access(8'hE0, 16'hCFFF, 1'b0, 1'b0, 1'b0, 1'b1);

        // Sweep all inhibit/select combinations over every page of every bank.
        for (int c = 0; c < 32; c++) begin
            write_cfg(c[4], c[3:0]);
            foreach (banks[i]) begin
                for (int p = 0; p < 17; p++) begin
                    automatic logic [15:0] a = (p == 16) ? 16'hD000 :
                        {4'hC, 4'(p), 8'($urandom_range(0, 255))};
                    access(banks[i], a, p[0], c[1], c[2], p[1]);
                end
            end
        end

        // Random accesses with occasional reconfiguration.
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 7) == 0)
                write_cfg($urandom_range(0, 1), 4'($urandom_range(0, 15)));
            access(banks[$urandom_range(0, 4)],
                   ($urandom_range(0, 5) == 0) ? 16'($urandom) :
                       {4'hC, 12'($urandom_range(0, 4095))},
                   $urandom_range(0, 1), $urandom_range(0, 1),
                   $urandom_range(0, 1), $urandom_range(0, 1));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule